// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block arbitrates three interrupt sources for a small 8-bit processor core: a USB event line and two timer overflow pulses. The CPU reads and writes its state through a single 8-bit control/status register. That register holds a global enable, one enable per source and one pending flag per source. A source pulse sets its pending flag. The flag stays set until the interrupt is serviced or software clears it.

Pending requests are examined only on a machine-cycle sampling strobe. At a strobe, a request qualifies when the global enable, its source enable and its flag are all set and the core's call stack is not full. The highest-priority qualified request is then acknowledged with a one-cycle pulse and its vector address. The acknowledge clears the serviced flag and the global enable. A return-from-interrupt indication (RETI) turns the global enable back on. A plain return (RET) leaves it alone. Software can nest interrupts by setting the enables again from inside a service routine.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every register bit reads 0 and `ack_o` is low.
- R2: A write with `wr_en_i` high and `addr_i` equal to 0x0B loads register bits 6..0 from `wdata_i`. The register layout is:
  - bit0: global enable.
  - bits 1, 2, 3: enables for USB, timer 0 and timer 1.
  - bits 4, 5, 6: pending flags for USB, timer 0 and timer 1.
  - bit7: always reads 0.
  
  `rdata_o` shows the register while `addr_i` is 0x0B and shows 0 at any other address. A write to any other address changes nothing.
- R3: A one-cycle pulse on `src_evt_i[k]` sets pending flag k. Index 0 is USB, index 1 is timer 0 and index 2 is timer 1.
- R4: `ack_o` rises in the cycle after a clock edge at which `strobe_i` was high and at least one source had its global enable, source enable and pending flag all set while `stack_full_i` was low. It stays high for exactly one cycle.
- R5: When several sources qualify, USB wins over timer 0, and timer 0 wins over timer 1. `vec_o` carries 0x04 for USB, 0x08 for timer 0 and 0x0C for timer 1 while `ack_o` is high, and 0 otherwise.
- R6: The acknowledge clears the serviced source's pending flag and the global enable bit. The other flags and all source enables are left unchanged.
- R7: While `stack_full_i` is high at a strobe, no acknowledge is issued and the register is unchanged. The request is acknowledged at a later strobe once `stack_full_i` is low.
- R8: A `reti_i` pulse sets the global enable bit. A `ret_i` pulse leaves it unchanged.
- R9: A source pulse in the same cycle as a CPU write of 0 to that source's flag leaves the flag set.
- R10: No acknowledge is issued in the cycle immediately after an acknowledge, even if the strobe and qualified requests are present.
- R11: Without a strobe, no acknowledge is issued, however long a qualified request waits.
- R12: Inside a service routine (global enable cleared by an acknowledge), software can write the global enable and a source enable back to 1. A pending request for that source is then acknowledged at the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 8 | CPU data address |
| wr_en_i | input | 1 | CPU write strobe |
| wdata_i | input | 8 | CPU write data |
| rdata_o | output | 8 | Register read data (0 when not addressed) |
| src_evt_i | input | 3 | Source event pulses: [0] USB, [1] timer 0, [2] timer 1 |
| stack_full_i | input | 1 | Core call stack is full |
| strobe_i | input | 1 | Machine-cycle sampling strobe |
| ret_i | input | 1 | Core executed a plain return |
| reti_i | input | 1 | Core executed a return-from-interrupt |
| ack_o | output | 1 | Interrupt acknowledge pulse |
| vec_o | output | 8 | Vector address of the acknowledged source |

## Verification
The bench runs every combination of the seven register bits against both stack-full states. Against that sweep it checks:
- A decoder with the wrong priority order would return the wrong vector.
- A design that ignored the global enable or a source enable would acknowledge where none is due.
- A design that cleared the wrong flag would show a mismatched register afterwards.

Directed sequences cover the remaining corner cases:
- A request held back by a full stack must survive and be acknowledged once the stack frees. A design that dropped it would never acknowledge.
- Back-to-back strobes must not double-acknowledge.
- RET must not re-enable interrupts, and RETI must.
- A source pulse must win over a simultaneous software clear. A design that lost it would miss an interrupt.
- A qualified request must wait for the strobe. A design that acknowledged combinationally would fire early.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int unsigned NUM_SRC = 3;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned EMI_BIT = 0;
  localparam int unsigned EN_LSB  = 1;
  localparam int unsigned FLG_LSB = EN_LSB + NUM_SRC;

  typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/irq_csr.sv
module irq_csr
  import irq_ctrl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [REG_W-2:0] wdata_i,
  input  src_vec_t         evt_i,
  input  logic             take_i,
  input  src_vec_t         clr_i,
  input  logic             reti_i,
  output logic             emi_o,
  output src_vec_t         en_o,
  output src_vec_t         flag_o,
  output logic [REG_W-1:0] reg_o
);
  logic     emi_q, emi_d;
  src_vec_t en_q, en_d, flg_q, flg_d;

  always_comb begin
    emi_d = emi_q;
    en_d  = en_q;
    flg_d = flg_q;
    if (wr_i) begin
      emi_d = wdata_i[EMI_BIT];
      en_d  = wdata_i[EN_LSB +: NUM_SRC];
      flg_d = wdata_i[FLG_LSB +: NUM_SRC];
    end
    if (reti_i) emi_d = 1'b1;
    if (take_i) begin
      emi_d = 1'b0;
      flg_d = flg_d & ~clr_i;
    end
    // hardware set wins over software clear and service clear
    flg_d = flg_d | evt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      emi_q <= 1'b0;
      en_q  <= '0;
      flg_q <= '0;
    end else begin
      emi_q <= emi_d;
      en_q  <= en_d;
      flg_q <= flg_d;
    end
  end

  assign emi_o  = emi_q;
  assign en_o   = en_q;
  assign flag_o = flg_q;
  assign reg_o  = {1'b0, flg_q, en_q, emi_q};

  // R9
  evt_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((flg_q & $past(evt_i)) == $past(evt_i)));

  // R8
  reti_sets_emi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && !take_i) |=> emi_q);
endmodule

// File: rtl/irq_arb.sv
module irq_arb
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned VEC_BASE = 4,
  parameter int unsigned VEC_STEP = 4
) (
  input  src_vec_t   req_i,
  output src_vec_t   grant_o,
  output logic [7:0] vec_o
);
  always_comb begin
    grant_o = '0;
    vec_o   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        grant_o    = '0;
        grant_o[i] = 1'b1;
        vec_o      = 8'(VEC_BASE + i * VEC_STEP);
      end
    end
  end

  // R5
  grant_onehot_chk: assert property (@(req_i) $onehot0(grant_o) && ((req_i == '0) == (grant_o == '0)));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [7:0]  REG_ADDR = 8'h0B,
  parameter int unsigned VEC_BASE = 4,
  parameter int unsigned VEC_STEP = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic [NUM_SRC-1:0] src_evt_i,
  input  logic              stack_full_i,
  input  logic              strobe_i,
  input  logic              ret_i,
  input  logic              reti_i,
  output logic              ack_o,
  output logic [7:0]        vec_o
);
  logic             sel, take, emi, ack_q;
  logic [7:0]       vec_q, vec_c;
  src_vec_t         en, flg, req, grant;
  logic [REG_W-1:0] reg_v;
  logic             unused_w;

  assign unused_w = wdata_i[REG_W-1] ^ ret_i;  // RET has no effect on state
  assign sel      = (addr_i == ADDR_W'(REG_ADDR));

  irq_csr u_csr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_en_i && sel),
    .wdata_i (wdata_i[REG_W-2:0]),
    .evt_i   (src_evt_i),
    .take_i  (take),
    .clr_i   (grant),
    .reti_i  (reti_i),
    .emi_o   (emi),
    .en_o    (en),
    .flag_o  (flg),
    .reg_o   (reg_v)
  );

  assign req = (emi && !stack_full_i && !ack_q) ? (en & flg) : '0;

  irq_arb #(.VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)) u_arb (
    .req_i   (req),
    .grant_o (grant),
    .vec_o   (vec_c)
  );

  assign take = strobe_i && (grant != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q <= 1'b0;
      vec_q <= '0;
    end else begin
      ack_q <= take;
      vec_q <= take ? vec_c : '0;
    end
  end

  assign ack_o   = ack_q;
  assign vec_o   = vec_q;
  assign rdata_o = sel ? reg_v : '0;

  // R10
  ack_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

  // R6
  ack_clears_emi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> !emi);

  // R11
  ack_needs_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> $past(strobe_i));

  // R7
  ack_stack_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> !$past(stack_full_i));

  // R5
  vec_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_o |-> (vec_o == 8'h00));
endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = 8'h0B;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [2:0] evt = 3'b000;
  logic       sf = 1'b0, strobe = 1'b0, ret = 1'b0, reti = 1'b0;
  logic       ack;
  logic [7:0] vec;
  int         checks = 0, errors = 0;
  bit         done = 0;

  always #10 clk = ~clk;

  prio_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .wdata_i(wdata),
    .rdata_o(rdata), .src_evt_i(evt), .stack_full_i(sf), .strobe_i(strobe),
    .ret_i(ret), .reti_i(reti), .ack_o(ack), .vec_o(vec)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] v);
    addr = 8'h0B; wr_en = 1'b1; wdata = v;
    step();
    wr_en = 1'b0;
  endtask

  task automatic strobe_once(input logic full);
    sf = full; strobe = 1'b1;
    step();
    strobe = 1'b0; sf = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(); step();
    chk("R1 reg", rdata, 0);
    chk("R1 ack", ack, 0);
    rst_n = 1'b1;
    step();
    chk("R1 reg after release", rdata, 0);

    // R2: bit7 reads 0, other address ignored
    wr(8'hFF);
    chk("R2 bit7", rdata, 8'h7F);
    wr(8'h00);
    addr = 8'h0A; wr_en = 1'b1; wdata = 8'h55; step(); wr_en = 1'b0;
    chk("R2 other addr read", rdata, 0);
    addr = 8'h0B;
    chk("R2 other addr write", rdata, 0);

    // R3: event pulses set flags
    for (int k = 0; k < 3; k++) begin
      evt = 3'(1 << k); step(); evt = 3'b000;
      chk("R3 flag set", rdata, 8'(1 << (4 + k)));
      wr(8'h00);
    end

    // R4 R5 R6 R7: exhaustive sweep
    for (int f = 0; f < 2; f++) begin
      for (int v = 0; v < 128; v++) begin
        int q, w, ev, er;
        wr(8'(v));
        strobe_once(f[0]);
        q = (v & 1) ? (((v >> 1) & (v >> 4)) & 7) : 0;
        if (f == 1) q = 0;
        w = -1;
        for (int i = 2; i >= 0; i--) if (q[i]) w = i;
        ev = (w < 0) ? 0 : 4 + 4 * w;
        er = (w < 0) ? v : (v & ~(1 << (4 + w)) & ~1);
        chk("R4 ack", ack, (w >= 0) ? 1 : 0);
        chk("R5 vector", vec, ev);
        chk(f ? "R7 reg held" : "R6 reg after", rdata, er);
        step();
        chk("R4 ack one cycle", ack, 0);
      end
    end

    // R7: held request serviced after stack frees
    wr(8'h25);
    strobe_once(1'b1);
    chk("R7 no ack", ack, 0);
    strobe_once(1'b0);
    chk("R7 ack later", ack, 1);
    chk("R7 vec", vec, 8'h08);
    chk("R7 reg", rdata, 8'h04);

    // R10: back-to-back strobes
    wr(8'h5F);
    sf = 1'b0; strobe = 1'b1; step();
    chk("R10 first ack", ack, 1);
    chk("R10 first vec", vec, 8'h04);
    step(); strobe = 1'b0;
    chk("R10 no second ack", ack, 0);
    chk("R10 reg", rdata, 8'h4E);

    // R8: RET leaves emi cleared, RETI sets it
    ret = 1'b1; step(); ret = 1'b0;
    chk("R8 ret", rdata, 8'h4E);
    reti = 1'b1; step(); reti = 1'b0;
    chk("R8 reti", rdata, 8'h4F);

    // R12: nesting via software write
    wr(8'h4E);
    strobe_once(1'b0);
    chk("R12 no ack emi off", ack, 0);
    wr(8'h4F);
    strobe_once(1'b0);
    chk("R12 nested ack", ack, 1);
    chk("R12 nested vec", vec, 8'h0C);
    chk("R12 reg", rdata, 8'h0E);

    // R9: event beats software clear
    wr(8'h70);
    addr = 8'h0B; wr_en = 1'b1; wdata = 8'h00; evt = 3'b010; step();
    wr_en = 1'b0; evt = 3'b000;
    chk("R9 flag kept", rdata, 8'h20);

    // R11: no strobe, no ack
    wr(8'h13);
    for (int c = 0; c < 6; c++) begin
      step();
      chk("R11 no ack", ack, 0);
    end
    strobe_once(1'b0);
    chk("R11 ack on strobe", ack, 1);
    chk("R11 vec", vec, 8'h04);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule